// File: doc/BRIEF.md
# I2C Synthesizer Register Interface

This block is an I2C target that loads the programming word of a frequency synthesizer and returns its status. SCL and SDA are sampled with the system clock. START and STOP conditions are recovered from those samples. Once a START is seen, the block compares the first byte with a fixed five-bit prefix followed by two address bits taken from pins. If they match, it takes part in the transfer. Otherwise it stays silent until the next START.

In a write, each data byte is steered by its top bit. A byte whose top bit is 0 opens a divider pair and carries the upper seven bits of the 15-bit division word. The byte after it supplies the lower eight bits. A byte whose top bit is 1 is a control byte, and the byte after it is the switch byte. A host can therefore update only the divider, only the control and switch settings, or both, in either order. Registers that are not written keep their values.

In a read, the block returns a status byte for as long as the host acknowledges. The status byte reports a power-on flag, the lock flag, the charge-current flag and a 3-bit converter code. The power-on flag clears when a read ends with a not-acknowledge. SDA is open-drain: the block only ever asks for the line to be pulled low.

Top module: `synth_i2c_if`

## Requirements
- R1: After reset the division word is 0, CP is 1, the test bits, the reference select and the amplifier-off bit are 0, all four switch outputs are 1 (off), SDA is released and the power-on flag is 1.
- R2: The block acknowledges an address byte only when its bits 7..1 equal 1,1,0,0,0,addr_sel[1],addr_sel[0]. Bit 0 is the direction: 0 means write and 1 means read. On a mismatch, SDA stays released and no register changes until the next START.
- R3: During an addressed write, the block pulls SDA low through the ninth SCL pulse of every data byte.
- R4: A byte with bit 7 = 0 that opens a pair loads nothing visible. Its bits 6..0 become n_word[14:8] only when the next byte arrives, and that byte supplies n_word[7:0] at the same moment.
- R5: A byte with bit 7 = 1 that opens a pair takes effect as soon as it is received: bit 6 drives cp_hi, bits 5..3 drive test_bits[2:0], bits 2..1 drive ref_sel[1:0] and bit 0 drives amp_off.
- R6: The byte that follows a control byte drives sw_n[3:0] from its bits 3..0. A 0 turns the switch on and a 1 turns it off. Bits 7..4 of that byte have no effect.
- R7: When a pair is complete, the next byte is steered again by its bit 7. A single transfer may therefore program the divider and the control/switch pair in either order.
- R8: If the transfer ends after the first byte of a divider pair, n_word is unchanged. If it ends after a control byte, sw_n is unchanged.
- R9: In a read, each byte sent MSB first is {POR, lock_i, acps_i, 1, 1, adc_code[2:0]}. A new byte follows every host acknowledge.
- R10: POR reads 1 until a read ends with a host not-acknowledge. It then reads 0 and stays 0 until reset.
- R11: SDA is released in the cycle after a STOP is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Programmable low address bits |
| lock_i | input | 1 | Loop lock flag, reported in status |
| acps_i | input | 1 | Automatic charge-current flag, reported in status |
| adc_code | input | 3 | Converter code, reported in status |
| n_word | output | 15 | Division ratio |
| cp_hi | output | 1 | Charge-pump high-current select |
| test_bits | output | 3 | Test mode bits |
| ref_sel | output | 2 | Reference divider select |
| amp_off | output | 1 | Tuning amplifier disable |
| sw_n | output | 4 | Band switch outputs, active low |

## Verification
The bound checker checks, on every cycle, four things:
- the division word moves only right after a received byte, and the control fields only right after a byte with bit 7 set;
- the switch outputs move only right after a received byte;
- POR falls only after a completed read and never rises again;
- SDA is let go after every STOP.

Only the bench's bus transactions can show the rest:
- address matching and the acknowledge timing;
- the routing of bytes into pairs, including mixed orders and abandoned pairs;
- the bit layout of the status byte.

// File: rtl/synth_i2c_pkg.sv
`timescale 1ns/1ps
package synth_i2c_pkg;
  localparam int NDIV_W = 15;
  localparam int SW_W = 4;
  localparam int ADC_W = 3;
  localparam int CTL_W = 7;
  localparam logic [4:0] ADDR_PREFIX = 5'b11000;

  typedef enum logic [2:0] {
    BS_IDLE, BS_RECV, BS_ACK, BS_SEND, BS_RACK, BS_RWAIT
  } bus_st_e;

  typedef enum logic [1:0] {RT_ANY, RT_NLO, RT_SW} route_e;

  typedef struct packed {
    logic       cp;
    logic [2:0] test;
    logic [1:0] ref_sel;
    logic       amp_off;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{cp: 1'b1, test: 3'd0, ref_sel: 2'd0, amp_off: 1'b0};
endpackage

// File: rtl/synth_i2c_cond_detect.sv
`timescale 1ns/1ps
module synth_i2c_cond_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_d, sda_s, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PW-2:0], scl_i};
      sda_pipe <= {sda_pipe[PW-2:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign scl_d = scl_pipe[SYNC_STAGES];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign sda_d = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign sda_lvl   = sda_s;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/synth_i2c_byte_engine.sv
`timescale 1ns/1ps
module synth_i2c_byte_engine
  import synth_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] addr_sel,
  input  logic [7:0] status_byte,
  output logic       sda_oe,
  output logic       byte_stb,
  output logic [7:0] byte_data,
  output logic       read_done
);
  bus_st_e    st_q, st_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d, tx_q, tx_d, rx_q, rx_d;
  logic       addr_ph_q, addr_ph_d, rw_q, rw_d, ackdrv_q, ackdrv_d;
  logic       stb_q, stb_d, done_q, done_d;
  logic [7:0] sh_in;

  assign sh_in = {sh_q[6:0], sda_lvl};

  always_comb begin
    st_d      = st_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    tx_d      = tx_q;
    rx_d      = rx_q;
    addr_ph_d = addr_ph_q;
    rw_d      = rw_q;
    ackdrv_d  = ackdrv_q;
    stb_d     = 1'b0;
    done_d    = 1'b0;
    case (st_q)
      BS_RECV: if (scl_rise) begin
        sh_d  = sh_in;
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          ackdrv_d = 1'b0;
          if (addr_ph_q) begin
            if (sh_in[7:1] == {ADDR_PREFIX, addr_sel}) begin
              rw_d = sh_in[0];
              st_d = BS_ACK;
            end else begin
              st_d = BS_IDLE;
            end
          end else begin
            stb_d = 1'b1;
            rx_d  = sh_in;
            st_d  = BS_ACK;
          end
        end
      end
      BS_ACK: if (scl_fall) begin
        if (!ackdrv_q) begin
          ackdrv_d = 1'b1;
        end else begin
          ackdrv_d  = 1'b0;
          addr_ph_d = 1'b0;
          bit_d     = 3'd0;
          if (rw_q) begin
            st_d = BS_SEND;
            tx_d = status_byte;
          end else begin
            st_d = BS_RECV;
          end
        end
      end
      BS_SEND: if (scl_fall) begin
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) st_d = BS_RACK;
        else               tx_d = {tx_q[6:0], 1'b1};
      end
      BS_RACK: if (scl_rise) begin
        if (sda_lvl) begin
          st_d   = BS_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = BS_RWAIT;
        end
      end
      BS_RWAIT: if (scl_fall) begin
        st_d  = BS_SEND;
        tx_d  = status_byte;
        bit_d = 3'd0;
      end
      default: ;
    endcase
    if (stop_det) st_d = BS_IDLE;
    if (start_det) begin
      st_d      = BS_RECV;
      bit_d     = 3'd0;
      addr_ph_d = 1'b1;
      ackdrv_d  = 1'b0;
      rw_d      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= BS_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '1;
      rx_q      <= '0;
      addr_ph_q <= 1'b0;
      rw_q      <= 1'b0;
      ackdrv_q  <= 1'b0;
      stb_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      tx_q      <= tx_d;
      rx_q      <= rx_d;
      addr_ph_q <= addr_ph_d;
      rw_q      <= rw_d;
      ackdrv_q  <= ackdrv_d;
      stb_q     <= stb_d;
      done_q    <= done_d;
    end
  end

  assign sda_oe    = ((st_q == BS_ACK) && ackdrv_q) || ((st_q == BS_SEND) && !tx_q[7]);
  assign byte_stb  = stb_q;
  assign byte_data = rx_q;
  assign read_done = done_q;
endmodule

// File: rtl/synth_reg_bank.sv
`timescale 1ns/1ps
module synth_reg_bank
  import synth_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_begin,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic              read_done,
  output logic [NDIV_W-1:0] n_word,
  output ctl_t              ctl,
  output logic [SW_W-1:0]   sw_n,
  output logic              por
);
  route_e            rt_q, rt_d;
  logic [6:0]        hi_q, hi_d;
  logic [NDIV_W-1:0] n_q, n_d;
  ctl_t              ctl_q, ctl_d;
  logic [SW_W-1:0]   sw_q, sw_d;
  logic              por_q, por_d;
  logic              n_en, ctl_en, sw_en, hi_en;

  always_comb begin
    rt_d   = rt_q;
    n_en   = 1'b0;
    ctl_en = 1'b0;
    sw_en  = 1'b0;
    hi_en  = 1'b0;
    if (xfer_begin) begin
      rt_d = RT_ANY;
    end else if (byte_stb) begin
      case (rt_q)
        RT_NLO: begin n_en = 1'b1; rt_d = RT_ANY; end
        RT_SW:  begin sw_en = 1'b1; rt_d = RT_ANY; end
        default: begin
          if (byte_data[7]) begin ctl_en = 1'b1; rt_d = RT_SW; end
          else              begin hi_en  = 1'b1; rt_d = RT_NLO; end
        end
      endcase
    end
    hi_d  = hi_en  ? byte_data[6:0] : hi_q;
    n_d   = n_en   ? {hi_q, byte_data} : n_q;
    ctl_d = ctl_en ? ctl_t'(byte_data[CTL_W-1:0]) : ctl_q;
    sw_d  = sw_en  ? byte_data[SW_W-1:0] : sw_q;
    por_d = read_done ? 1'b0 : por_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_q  <= RT_ANY;
      hi_q  <= '0;
      n_q   <= '0;
      ctl_q <= CTL_RESET;
      sw_q  <= '1;
      por_q <= 1'b1;
    end else begin
      rt_q  <= rt_d;
      hi_q  <= hi_d;
      n_q   <= n_d;
      ctl_q <= ctl_d;
      sw_q  <= sw_d;
      por_q <= por_d;
    end
  end

  assign n_word = n_q;
  assign ctl    = ctl_q;
  assign sw_n   = sw_q;
  assign por    = por_q;
endmodule

// File: rtl/synth_i2c_if.sv
`timescale 1ns/1ps
module synth_i2c_if
  import synth_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic              lock_i,
  input  logic              acps_i,
  input  logic [ADC_W-1:0]  adc_code,
  output logic [NDIV_W-1:0] n_word,
  output logic              cp_hi,
  output logic [2:0]        test_bits,
  output logic [1:0]        ref_sel,
  output logic              amp_off,
  output logic [SW_W-1:0]   sw_n
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic       byte_stb, read_done, por_q;
  logic [7:0] byte_data, status_byte;
  ctl_t       ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign status_byte = {por_q, lock_i, acps_i, 2'b11, adc_code};

  synth_i2c_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det)
  );

  synth_i2c_byte_engine u_eng (
    .clk(clk), .rst_n(rst_sync_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .status_byte(status_byte), .sda_oe(sda_oe),
    .byte_stb(byte_stb), .byte_data(byte_data), .read_done(read_done)
  );

  synth_reg_bank u_bank (
    .clk(clk), .rst_n(rst_sync_n), .xfer_begin(start_det), .byte_stb(byte_stb),
    .byte_data(byte_data), .read_done(read_done), .n_word(n_word),
    .ctl(ctl_q), .sw_n(sw_n), .por(por_q)
  );

  assign cp_hi     = ctl_q.cp;
  assign test_bits = ctl_q.test;
  assign ref_sel   = ctl_q.ref_sel;
  assign amp_off   = ctl_q.amp_off;
endmodule

// File: rtl/synth_i2c_chk.sv
`timescale 1ns/1ps
module synth_i2c_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        byte_stb,
  input logic [7:0]  byte_data,
  input logic        read_done,
  input logic        stop_det,
  input logic        sda_oe,
  input logic        por_q,
  input logic [14:0] n_word,
  input logic [6:0]  ctl_flat,
  input logic [3:0]  sw_n
);
  AST_N_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(n_word) |-> $past(byte_stb)); // R4

  AST_CTL_AFTER_CTRL_BYTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(ctl_flat) |-> $past(byte_stb && byte_data[7])); // R5

  AST_SW_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(sw_n) |-> $past(byte_stb)); // R6

  AST_POR_FALL_ON_READ_END: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(por_q) |-> $past(read_done)); // R10

  AST_POR_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$rose(por_q)); // R10

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stop_det |=> !sda_oe); // R11
endmodule

bind synth_i2c_if synth_i2c_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .byte_stb(byte_stb), .byte_data(byte_data),
  .read_done(read_done), .stop_det(stop_det), .sda_oe(sda_oe), .por_q(por_q),
  .n_word(n_word), .ctl_flat({cp_hi, test_bits, ref_sel, amp_off}), .sw_n(sw_n)
);

// File: tb/synth_i2c_if_test.sv
`timescale 1ns/1ps
module synth_i2c_if_test;
  localparam int Q = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_i;
  logic        sda_oe;
  logic [1:0]  addr_sel = 2'b10;
  logic        lock_i = 1'b0;
  logic        acps_i = 1'b1;
  logic [2:0]  adc_code = 3'd0;
  logic [14:0] n_word;
  logic        cp_hi, amp_off;
  logic [2:0]  test_bits;
  logic [1:0]  ref_sel;
  logic [3:0]  sw_n;

  int nchk = 0;
  int nerr = 0;
  logic [14:0] exp_n = '0;
  logic [6:0]  exp_ctl = 7'b1000000;
  logic [3:0]  exp_sw = 4'hF;
  logic        exp_por = 1'b1;
  logic [7:0]  txb [6];

  always #2.5 clk = ~clk;
  assign sda_i = sda_m & ~sda_oe;

  synth_i2c_if uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .acps_i(acps_i), .adc_code(adc_code),
    .n_word(n_word), .cp_hi(cp_hi), .test_bits(test_bits), .ref_sel(ref_sel),
    .amp_off(amp_off), .sw_n(sw_n)
  );

  task automatic check(input string msg, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_i; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) recv_bit(b[i]);
    send_bit(~mack);
  endtask

  function automatic logic [7:0] exp_status();
    return {exp_por, lock_i, acps_i, 2'b11, adc_code};
  endfunction

  task automatic check_regs(input string tag);
    check({tag, " n_word"}, n_word, exp_n);
    check({tag, " control fields"}, {cp_hi, test_bits, ref_sel, amp_off}, exp_ctl);
    check({tag, " switch outputs"}, sw_n, exp_sw);
  endtask

  task automatic do_write(input logic [6:0] a7, input int cnt, input string tag);
    logic ack, match;
    int r;
    logic [6:0] hi;
    match = (a7 == {5'b11000, addr_sel});
    r = 0;
    hi = '0;
    i2c_start();
    send_byte({a7, 1'b0}, ack);
    check("R2 address acknowledge", ack, match);
    for (int j = 0; j < cnt; j++) begin
      send_byte(txb[j], ack);
      if (match) begin
        check("R3 data acknowledge", ack, 1);
        case (r)
          0: if (txb[j][7]) begin exp_ctl = txb[j][6:0]; r = 2; end
             else begin hi = txb[j][6:0]; r = 1; end
          1: begin exp_n = {hi, txb[j]}; r = 0; end
          default: begin exp_sw = txb[j][3:0]; r = 0; end
        endcase
      end else begin
        check("R2 silent when not addressed", ack, 0);
      end
    end
    i2c_stop();
    tick(4);
    check("R11 SDA released after STOP", sda_oe, 0);
    check_regs(tag);
  endtask

  task automatic do_read(input int nb);
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte({5'b11000, addr_sel, 1'b1}, ack);
    check("R2 read address acknowledge", ack, 1);
    for (int k = 0; k < nb; k++) begin
      recv_byte(k < nb - 1, b);
      check("R9 status byte", b, exp_status());
      check("R10 POR flag", b[7], exp_por);
    end
    i2c_stop();
    exp_por = 1'b0;
    tick(4);
    check("R11 SDA released after read", sda_oe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'd20250611));
    tick(5);
    rst_n = 1'b1;
    tick(10);
    // R1 reset state
    check_regs("R1");
    check("R1 SDA released", sda_oe, 0);

    // R2 wrong address: divider pair must be ignored
    txb[0] = 8'h12; txb[1] = 8'h34;
    do_write(7'b1100001, 2, "R2 mismatch");

    // R4 the first divider byte alone changes nothing visible
    i2c_start();
    send_byte({5'b11000, addr_sel, 1'b0}, ack);
    check("R2 address acknowledge", ack, 1);
    send_byte(8'h5A, ack);
    check("R4 n_word held after first byte", n_word, 15'd0);
    send_byte(8'hC3, ack);
    exp_n = {7'h5A, 8'hC3};
    check("R4 n_word after pair", n_word, exp_n);
    // R5 control applies at once; R6 switch held until its own byte
    send_byte(8'b1_0_101_10_1, ack);
    exp_ctl = 7'b0_101_10_1;
    check("R5 control applied", {cp_hi, test_bits, ref_sel, amp_off}, exp_ctl);
    check("R6 switch held before switch byte", sw_n, 4'hF);
    send_byte(8'hA5, ack);
    exp_sw = 4'h5;
    check("R6 switch low nibble, high nibble ignored", sw_n, exp_sw);
    i2c_stop();
    tick(4);

    // R7 control/switch first, then divider, in one transfer
    txb[0] = 8'hFE; txb[1] = 8'h0C; txb[2] = 8'h7F; txb[3] = 8'h01;
    do_write({5'b11000, addr_sel}, 4, "R7");

    // R8 abandoned divider pair, then lone control byte
    txb[0] = 8'h33;
    do_write({5'b11000, addr_sel}, 1, "R8 lone divider byte");
    txb[0] = 8'h81;
    do_write({5'b11000, addr_sel}, 1, "R8 lone control byte");

    // R2 other address select
    addr_sel = 2'b01;
    txb[0] = 8'h01; txb[1] = 8'h02;
    do_write(7'b1100001, 2, "R2 new address");

    // R9 / R10 reads
    lock_i = 1'b1; acps_i = 1'b0; adc_code = 3'd5;
    do_read(3);
    lock_i = 1'b0; acps_i = 1'b1; adc_code = 3'd2;
    do_read(1);

    // random transactions
    for (int t = 0; t < 40; t++) begin
      int kind, cnt;
      logic [6:0] a7;
      logic [14:0] nv;
      nv = 15'($urandom);
      a7 = ($urandom_range(0, 5) == 0) ? 7'($urandom) : {5'b11000, addr_sel};
      kind = $urandom_range(0, 5);
      cnt = 0;
      if (kind == 0 || kind == 2) begin
        txb[cnt] = {1'b0, nv[14:8]}; txb[cnt+1] = nv[7:0]; cnt += 2;
      end
      if (kind == 1 || kind == 2 || kind == 3) begin
        txb[cnt] = {1'b1, 7'($urandom)}; txb[cnt+1] = 8'($urandom); cnt += 2;
      end
      if (kind == 3) begin
        txb[cnt] = {1'b0, nv[14:8]}; txb[cnt+1] = nv[7:0]; cnt += 2;
      end
      if (kind == 4) begin
        txb[0] = {1'($urandom), 7'($urandom)}; cnt = 1;
      end
      if (kind == 5) begin
        lock_i = 1'($urandom); acps_i = 1'($urandom); adc_code = 3'($urandom);
        do_read($urandom_range(1, 3));
      end else begin
        do_write(a7, cnt, "R7 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule